// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Exception Entry Sequencer

This block chooses which pending interrupt, if any, the processor takes at the next instruction boundary, and then carries out the hardware part of exception entry. Each peripheral source has a programmable priority level from 1 to 7; level 0 switches a source off. Levels 1 to 6 are level-sensitive and compete only when they are above the 3-bit mask held in the status word. Level 7 is edge-triggered, is captured in a per-source latch and is never masked. Two sources can be promoted into two extra slots at the top of level 6. A synchronous fault request from the core beats any interrupt.

Once an exception is accepted, the sequencer saves the old status word and then updates it: supervisor on, trace off and, for an interrupt, the master bit cleared and the mask raised to the level being serviced. It writes a two-word frame below the supervisor stack pointer and reads the handler address from the table at the vector base plus four times the vector number. The core gives one strobe per instruction boundary. The strobe that follows a completed entry is not used for interrupt sampling, so the first handler instruction always runs.

Top module: `irq_exc_ctrl`

## Requirements
- R1: After reset the status word is 0x2700 (supervisor bit 13 set, mask bits 10:8 equal to 7), the vector base is 0, and no memory access or entry is in progress.
- R2: A source with level L from 1 to 6 is taken only while it requests and L is greater than the mask. L equal to or below the mask blocks it.
- R3: A rising edge on a level-7 source is latched and taken even when the mask is 7, and even when the pulse ends before the next strobe. A line held high gives exactly one entry, and taking the source clears its latch.
- R4: The highest effective level wins. Among equal levels the lower source index wins. An interrupt uses vector number 64 plus the source index.
- R5: A source selected by boost slot A, or by boost slot B, with a configured level from 1 to 6, ranks as level 6 above every plain level-6 source. Slot A ranks above slot B. A boosted source is masked as level 6.
- R6: Entry starts only on a cycle with the boundary strobe. After an entry completes, the next strobe samples no interrupt and the one after it does.
- R7: On entry, status bit 13 is set and bit 15 is cleared. An interrupt also clears bit 12 and writes its level into bits 10:8.
- R8: The frame is written on two consecutive cycles. The first write stores the return PC at SSP-4. The second stores {8'h40, vector[7:0], old status[15:0]} at SSP-8. frame_sp reports SSP-8.
- R9: One cycle after the second frame write, a read is issued at vector base + 4*vector. The returned word appears on handler_pc with a one-cycle entry_done pulse two cycles after the read.
- R10: A fault request at a strobe is taken with its own vector in place of any interrupt. It leaves bit 12 and the mask unchanged, and the pending interrupt is taken later.
- R11: Status writes keep only bits 15, 13, 12, 10:8 and 4:0. All other bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Request lines, one per source |
| irq_level | input | 3*N_SRC | Level per source, source i at bits 3i+2:3i |
| boost_a_en | input | 1 | Enable boost slot A |
| boost_a_idx | input | IDX_W | Source promoted by slot A |
| boost_b_en | input | 1 | Enable boost slot B |
| boost_b_idx | input | IDX_W | Source promoted by slot B |
| insn_boundary | input | 1 | One-cycle strobe at each instruction boundary |
| fault_req | input | 1 | Processor exception request |
| fault_vec | input | 8 | Vector number of the processor exception |
| pc_in | input | ADDR_W | Return PC captured at entry |
| ssp_in | input | ADDR_W | Supervisor stack pointer captured at entry |
| status_wr | input | 1 | Write the status word (idle only) |
| status_wdata | input | 16 | Status write data |
| vbr_wr | input | 1 | Write the vector base (idle only) |
| vbr_wdata | input | ADDR_W | Vector base write data |
| status | output | 16 | Current status word |
| vbr | output | ADDR_W | Current vector base |
| mem_we | output | 1 | Frame write strobe |
| mem_waddr | output | ADDR_W | Frame write address |
| mem_wdata | output | 32 | Frame write data |
| mem_re | output | 1 | Vector table read strobe |
| mem_raddr | output | ADDR_W | Vector table read address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |
| busy | output | 1 | Entry sequence in progress |
| entry_done | output | 1 | One-cycle pulse when the handler address is ready |
| entry_vector | output | 8 | Vector number of the current or last entry |
| handler_pc | output | 32 | Handler address from the table |
| frame_sp | output | ADDR_W | Stack pointer after the frame push |

## Verification
A wrong rank or mask compare inside the arbiter shows up in the cycle after the strobe. busy either stays low or rises, and entry_vector, the mask bits of status and the vector in the second frame word all name the wrong source. A stale or lost level-7 latch appears as a missing entry, or as an extra one on the strobe after the skipped one. A sequencer that is out of step shows within four cycles of the strobe as a frame address, frame word order, read address or handler value that does not match.

// File: rtl/irq_exc_pkg.sv
package irq_exc_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_TOP   = 3'd7;
    localparam logic [LVL_W-1:0] LVL_BOOST = 3'd6;

    localparam int SR_BIT_T   = 15;
    localparam int SR_BIT_S   = 13;
    localparam int SR_BIT_M   = 12;
    localparam int SR_MASK_LO = 8;

    localparam logic [15:0] SR_RESET      = 16'h2700;
    localparam logic [15:0] SR_WRITE_KEEP = 16'hB71F;

    localparam logic [7:0] FRAME_TAG    = 8'h40;
    localparam logic [7:0] IRQ_VEC_BASE = 8'd64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_FETCH,
        ST_WAIT
    } seq_state_e;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic arm,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } latch_t;

    latch_t q, d;

    always_comb begin
        d      = q;
        d.prev = req;
        d.pend = (q.pend && !clr) || (req && !q.prev && arm);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_exc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] level,
    input  logic [N_SRC-1:0]       pend7,
    input  logic                   boost_a_en,
    input  logic [IDX_W-1:0]       boost_a_idx,
    input  logic                   boost_b_en,
    input  logic [IDX_W-1:0]       boost_b_idx,
    input  logic [LVL_W-1:0]       mask,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output logic [LVL_W-1:0]       win_level
);
    localparam int RANK_W = LVL_W + 2;

    logic [N_SRC-1:0]  elig;
    logic [RANK_W-1:0] rank    [N_SRC];
    logic [LVL_W-1:0]  eff_lvl [N_SRC];

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [LVL_W-1:0] lvl;
        logic             sel_a;
        logic             sel_b;
        logic             live_lvl;
        logic [LVL_W-1:0] e;
        logic [1:0]       sub;

        assign lvl      = level[i*LVL_W +: LVL_W];
        assign sel_a    = boost_a_en && (boost_a_idx == IDX_W'(i));
        assign sel_b    = boost_b_en && (boost_b_idx == IDX_W'(i));
        assign live_lvl = req[i] && (lvl != '0) && (lvl != LVL_TOP);
        assign e        = pend7[i] ? LVL_TOP :
                          ((sel_a || sel_b) ? LVL_BOOST : lvl);
        assign sub      = pend7[i] ? 2'b00 :
                          (sel_a ? 2'b11 : (sel_b ? 2'b10 : 2'b00));
        assign elig[i]    = pend7[i] || (live_lvl && (e > mask));
        assign rank[i]    = {e, sub};
        assign eff_lvl[i] = e;
    end

    always_comb begin
        logic [RANK_W-1:0] best;
        best      = '0;
        win_valid = 1'b0;
        win_idx   = '0;
        win_level = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (rank[i] > best)) begin
                best      = rank[i];
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_level = eff_lvl[i];
            end
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import irq_exc_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_boundary,
    input  logic              fault_req,
    input  logic [7:0]        fault_vec,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [LVL_W-1:0]  win_level,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic              status_wr,
    input  logic [15:0]       status_wdata,
    input  logic              vbr_wr,
    input  logic [ADDR_W-1:0] vbr_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              take_irq,
    output logic [15:0]       status,
    output logic [ADDR_W-1:0] vbr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [31:0]       mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              busy,
    output logic              entry_done,
    output logic [7:0]        entry_vector,
    output logic [31:0]       handler_pc,
    output logic [ADDR_W-1:0] frame_sp
);
    typedef struct packed {
        seq_state_e        state;
        logic [15:0]       sr;
        logic [ADDR_W-1:0] vbr;
        logic [7:0]        vec;
        logic [15:0]       saved;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic [31:0]       handler;
        logic              done;
        logic              skip;
    } seq_t;

    seq_t q, d;

    always_comb begin
        logic start;
        d        = q;
        d.done   = 1'b0;
        take_irq = 1'b0;
        start    = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (insn_boundary) begin
                    if (fault_req) begin
                        start            = 1'b1;
                        d.vec            = fault_vec;
                        d.sr[SR_BIT_S]   = 1'b1;
                        d.sr[SR_BIT_T]   = 1'b0;
                    end else if (q.skip) begin
                        d.skip = 1'b0;
                    end else if (win_valid) begin
                        start          = 1'b1;
                        take_irq       = 1'b1;
                        d.vec          = IRQ_VEC_BASE + 8'(win_idx);
                        d.sr[SR_BIT_S] = 1'b1;
                        d.sr[SR_BIT_T] = 1'b0;
                        d.sr[SR_BIT_M] = 1'b0;
                        d.sr[SR_MASK_LO +: LVL_W] = win_level;
                    end
                end
                if (start) begin
                    d.state = ST_PUSH_PC;
                    d.saved = q.sr;
                    d.pc    = pc_in;
                    d.sp    = ssp_in;
                end else begin
                    if (status_wr) d.sr  = status_wdata & SR_WRITE_KEEP;
                    if (vbr_wr)    d.vbr = vbr_wdata;
                end
            end
            ST_PUSH_PC: d.state = ST_PUSH_SR;
            ST_PUSH_SR: d.state = ST_FETCH;
            ST_FETCH:   d.state = ST_WAIT;
            ST_WAIT: begin
                d.handler = mem_rdata;
                d.done    = 1'b1;
                d.skip    = 1'b1;
                d.state   = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.sr    <= SR_RESET;
        end else begin
            q <= d;
        end
    end

    assign status       = q.sr;
    assign vbr          = q.vbr;
    assign busy         = (q.state != ST_IDLE);
    assign mem_we       = (q.state == ST_PUSH_PC) || (q.state == ST_PUSH_SR);
    assign mem_waddr    = (q.state == ST_PUSH_PC) ? (q.sp - ADDR_W'(4))
                                                  : (q.sp - ADDR_W'(8));
    assign mem_wdata    = (q.state == ST_PUSH_PC) ? 32'(q.pc)
                                                  : {FRAME_TAG, q.vec, q.saved};
    assign mem_re       = (q.state == ST_FETCH);
    assign mem_raddr    = q.vbr + ADDR_W'({q.vec, 2'b00});
    assign entry_done   = q.done;
    assign entry_vector = q.vec;
    assign handler_pc   = q.handler;
    assign frame_sp     = q.sp - ADDR_W'(8);
endmodule

// File: rtl/irq_exc_ctrl.sv
module irq_exc_ctrl
    import irq_exc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       irq_req,
    input  logic [N_SRC*LVL_W-1:0] irq_level,
    input  logic                   boost_a_en,
    input  logic [IDX_W-1:0]       boost_a_idx,
    input  logic                   boost_b_en,
    input  logic [IDX_W-1:0]       boost_b_idx,
    input  logic                   insn_boundary,
    input  logic                   fault_req,
    input  logic [7:0]             fault_vec,
    input  logic [ADDR_W-1:0]      pc_in,
    input  logic [ADDR_W-1:0]      ssp_in,
    input  logic                   status_wr,
    input  logic [15:0]            status_wdata,
    input  logic                   vbr_wr,
    input  logic [ADDR_W-1:0]      vbr_wdata,
    output logic [15:0]            status,
    output logic [ADDR_W-1:0]      vbr,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_waddr,
    output logic [31:0]            mem_wdata,
    output logic                   mem_re,
    output logic [ADDR_W-1:0]      mem_raddr,
    input  logic [31:0]            mem_rdata,
    output logic                   busy,
    output logic                   entry_done,
    output logic [7:0]             entry_vector,
    output logic [31:0]            handler_pc,
    output logic [ADDR_W-1:0]      frame_sp
);
    logic [N_SRC-1:0] pend7;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_level;
    logic             take_irq;

    for (genvar i = 0; i < N_SRC; i++) begin : g_edge
        irq_edge_latch u_latch (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (irq_req[i]),
            .arm  (irq_level[i*LVL_W +: LVL_W] == LVL_TOP),
            .clr  (take_irq && (win_idx == IDX_W'(i))),
            .pend (pend7[i])
        );
    end

    irq_prio_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .req        (irq_req),
        .level      (irq_level),
        .pend7      (pend7),
        .boost_a_en (boost_a_en),
        .boost_a_idx(boost_a_idx),
        .boost_b_en (boost_b_en),
        .boost_b_idx(boost_b_idx),
        .mask       (status[SR_MASK_LO +: LVL_W]),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_level  (win_level)
    );

    exc_entry_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .insn_boundary(insn_boundary),
        .fault_req    (fault_req),
        .fault_vec    (fault_vec),
        .win_valid    (win_valid),
        .win_idx      (win_idx),
        .win_level    (win_level),
        .pc_in        (pc_in),
        .ssp_in       (ssp_in),
        .status_wr    (status_wr),
        .status_wdata (status_wdata),
        .vbr_wr       (vbr_wr),
        .vbr_wdata    (vbr_wdata),
        .mem_rdata    (mem_rdata),
        .take_irq     (take_irq),
        .status       (status),
        .vbr          (vbr),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .mem_re       (mem_re),
        .mem_raddr    (mem_raddr),
        .busy         (busy),
        .entry_done   (entry_done),
        .entry_vector (entry_vector),
        .handler_pc   (handler_pc),
        .frame_sp     (frame_sp)
    );
endmodule

// File: rtl/irq_exc_ctrl_chk.sv
module irq_exc_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_boundary,
    input logic              fault_req,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic              mem_re,
    input logic              entry_done,
    input logic              st_trace,
    input logic              st_super,
    input logic [2:0]        st_mask
);
    assert_frame_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |=> (mem_we && (mem_waddr == $past(mem_waddr) - ADDR_W'(4))));

    assert_fetch_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ##2 entry_done);

    assert_entry_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (st_super && !st_trace));

    assert_sample_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_boundary));

    assert_mask_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(fault_req)) |-> ((st_mask > $past(st_mask)) || (st_mask == 3'd7)));
endmodule

bind irq_exc_ctrl irq_exc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_boundary(insn_boundary),
    .fault_req    (fault_req),
    .busy         (busy),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_re       (mem_re),
    .entry_done   (entry_done),
    .st_trace     (status[15]),
    .st_super     (status[13]),
    .st_mask      (status[10:8])
);

// File: tb/test_irq_exc_ctrl.sv
`timescale 1ns/1ps
module test_irq_exc_ctrl;
    localparam int N_SRC = 8;
    localparam logic [31:0] PC_V  = 32'h0000_4A00;
    localparam logic [31:0] SSP_V = 32'h0080_0100;

    // row: {req[7:0], mask[2:0], taken, vector[7:0], level[2:0]}
    localparam int NROW = 10;
    localparam logic [22:0] TBL [NROW] = '{
        {8'h08, 3'd3, 1'b1, 8'd67, 3'd4},
        {8'h08, 3'd4, 1'b0, 8'd0,  3'd0},
        {8'h08, 3'd5, 1'b0, 8'd0,  3'd0},
        {8'h09, 3'd0, 1'b1, 8'd67, 3'd4},
        {8'h60, 3'd0, 1'b1, 8'd69, 3'd6},
        {8'h01, 3'd0, 1'b1, 8'd64, 3'd1},
        {8'h01, 3'd1, 1'b0, 8'd0,  3'd0},
        {8'h7F, 3'd5, 1'b1, 8'd69, 3'd6},
        {8'h06, 3'd2, 1'b1, 8'd66, 3'd3},
        {8'h00, 3'd0, 1'b0, 8'd0,  3'd0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [N_SRC-1:0] irq_req;
    logic [N_SRC*3-1:0] irq_level;
    logic boost_a_en, boost_b_en;
    logic [2:0] boost_a_idx, boost_b_idx;
    logic insn_boundary, fault_req;
    logic [7:0] fault_vec;
    logic status_wr, vbr_wr;
    logic [15:0] status_wdata;
    logic [31:0] vbr_wdata;
    logic [15:0] status;
    logic [31:0] vbr, mem_waddr, mem_wdata, mem_raddr, handler_pc, frame_sp;
    logic [31:0] mem_rdata;
    logic mem_we, mem_re, busy, entry_done;
    logic [7:0] entry_vector;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic got;
    logic [7:0]  g_vec;
    logic [15:0] g_stat;
    logic [31:0] g_handler, g_fsp, ra;
    logic [31:0] wa [2];
    logic [31:0] wd [2];
    int nw;

    always #2.5 clk = ~clk;

    irq_exc_ctrl #(.N_SRC(N_SRC), .ADDR_W(32)) i_irq_exc_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
        .boost_a_en(boost_a_en), .boost_a_idx(boost_a_idx),
        .boost_b_en(boost_b_en), .boost_b_idx(boost_b_idx),
        .insn_boundary(insn_boundary), .fault_req(fault_req), .fault_vec(fault_vec),
        .pc_in(PC_V), .ssp_in(SSP_V),
        .status_wr(status_wr), .status_wdata(status_wdata),
        .vbr_wr(vbr_wr), .vbr_wdata(vbr_wdata),
        .status(status), .vbr(vbr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .busy(busy), .entry_done(entry_done), .entry_vector(entry_vector),
        .handler_pc(handler_pc), .frame_sp(frame_sp)
    );

    // vector table model: word = A5 in top byte, address low 24 bits below
    always_ff @(posedge clk) if (mem_re) mem_rdata <= {8'hA5, mem_raddr[23:0]};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_req = '0; boost_a_en = 0; boost_b_en = 0; boost_a_idx = 0; boost_b_idx = 0;
        insn_boundary = 0; fault_req = 0; fault_vec = 0;
        status_wr = 0; status_wdata = 0; vbr_wr = 0; vbr_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_status(input logic [15:0] v);
        @(negedge clk) begin status_wr = 1; status_wdata = v; end
        @(negedge clk) status_wr = 0;
    endtask

    task automatic run_entry();
        @(negedge clk) insn_boundary = 1;
        @(negedge clk) insn_boundary = 0;
        got = 0; nw = 0; ra = '0;
        for (int k = 0; k < 8; k++) begin
            if (!got) begin
                if (mem_we) begin
                    if (nw < 2) begin wa[nw] = mem_waddr; wd[nw] = mem_wdata; end
                    nw++;
                end
                if (mem_re) ra = mem_raddr;
                if (entry_done) begin
                    got = 1; g_vec = entry_vector; g_stat = status;
                    g_handler = handler_pc; g_fsp = frame_sp;
                end else begin
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic check_entry(input logic [7:0] vec, input logic [15:0] old_sr,
                               input logic [15:0] new_sr, input logic [31:0] vb);
        logic [31:0] exp_ra;
        exp_ra = vb + {22'd0, vec, 2'b00};
        check("R6 entry taken", 32'(got), 32'd1);
        if (got) begin
            check("R4 vector", 32'(g_vec), 32'(vec));
            check("R7 status after entry", 32'(g_stat), 32'(new_sr));
            check("R8 write count", 32'(nw), 32'd2);
            check("R8 pc address", wa[0], SSP_V - 32'd4);
            check("R8 pc data", wd[0], PC_V);
            check("R8 status word address", wa[1], SSP_V - 32'd8);
            check("R8 status word data", wd[1], {8'h40, vec, old_sr});
            check("R8 frame_sp", g_fsp, SSP_V - 32'd8);
            check("R9 table address", ra, exp_ra);
            check("R9 handler", g_handler, {8'hA5, exp_ra[23:0]});
        end
    endtask

    task automatic check_none(input string tag);
        check(tag, 32'(got), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // source levels: src0..src7 = 1,2,3,4,5,6,6,7
        irq_level = {3'd7, 3'd6, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1};

        // R1 reset state
        do_reset();
        check("R1 status reset", 32'(status), 32'h2700);
        check("R1 vbr reset", vbr, 32'd0);
        check("R1 busy reset", 32'(busy), 32'd0);
        check("R1 no write at reset", 32'(mem_we), 32'd0);

        // table of mask and arbitration cases (R2, R4)
        for (int r = 0; r < NROW; r++) begin
            logic [7:0]  t_req;
            logic [2:0]  t_mask, t_lvl;
            logic        t_take;
            logic [7:0]  t_vec;
            logic [15:0] old_sr;
            {t_req, t_mask, t_take, t_vec, t_lvl} = TBL[r];
            old_sr = 16'h2000 | (16'(t_mask) << 8);
            do_reset();
            set_status(old_sr);
            irq_req = t_req;
            run_entry();
            irq_req = '0;
            if (t_take) check_entry(t_vec, old_sr, 16'h2000 | (16'(t_lvl) << 8), 32'd0);
            else        check_none("R2 blocked at or below mask");
        end

        // R3 short level-7 pulse between strobes, mask 7
        do_reset();
        @(negedge clk) irq_req[7] = 1;
        @(negedge clk) irq_req[7] = 0;
        repeat (3) @(negedge clk);
        run_entry();
        check_entry(8'd71, 16'h2700, 16'h2700, 32'd0);
        run_entry();
        check_none("R6 first strobe after entry skipped");
        irq_req[7] = 1;
        run_entry();
        check_entry(8'd71, 16'h2700, 16'h2700, 32'd0);
        run_entry();
        run_entry();
        check_none("R3 held level-7 line enters once");
        irq_req = '0;

        // R6 no entry without strobe, and skip after entry
        do_reset();
        set_status(16'h2000);
        irq_req = 8'h08;
        begin
            logic seen;
            seen = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (busy || mem_we) seen = 1;
            end
            check("R6 no entry without strobe", 32'(seen), 32'd0);
        end
        run_entry();
        check_entry(8'd67, 16'h2000, 16'h2400, 32'd0);
        irq_req = 8'h20;
        run_entry();
        check_none("R6 skipped strobe after handler entry");
        run_entry();
        check_entry(8'd69, 16'h2400, 16'h2600, 32'd0);
        irq_req = '0;

        // R5 boost slots
        do_reset();
        boost_a_en = 1; boost_a_idx = 3'd0;
        set_status(16'h2000);
        irq_req = 8'h21;
        run_entry();
        check_entry(8'd64, 16'h2000, 16'h2600, 32'd0);
        do_reset();
        boost_a_en = 1; boost_a_idx = 3'd0; boost_b_en = 1; boost_b_idx = 3'd1;
        set_status(16'h2000);
        irq_req = 8'h22;
        run_entry();
        check("R5 slot B above plain level 6", 32'(g_vec), 32'd65);
        do_reset();
        boost_a_en = 1; boost_a_idx = 3'd0; boost_b_en = 1; boost_b_idx = 3'd1;
        set_status(16'h2000);
        irq_req = 8'h03;
        run_entry();
        check("R5 slot A above slot B", 32'(g_vec), 32'd64);
        do_reset();
        boost_a_en = 1; boost_a_idx = 3'd0;
        set_status(16'h2600);
        irq_req = 8'h01;
        run_entry();
        check_none("R5 boosted source masked as level 6");
        irq_req = '0;

        // R10 fault beats interrupt, keeps M and mask
        do_reset();
        set_status(16'h9000);
        irq_req = 8'h08;
        fault_req = 1; fault_vec = 8'd3;
        run_entry();
        fault_req = 0;
        check_entry(8'd3, 16'h9000, 16'h3000, 32'd0);
        run_entry();
        check_none("R10 skip after fault entry");
        run_entry();
        check_entry(8'd67, 16'h3000, 16'h2400, 32'd0);
        irq_req = '0;

        // R9 relocated table
        do_reset();
        @(negedge clk) begin vbr_wr = 1; vbr_wdata = 32'h0000_1000; end
        @(negedge clk) vbr_wr = 0;
        check("R9 vbr written", vbr, 32'h0000_1000);
        set_status(16'h2000);
        irq_req = 8'h08;
        run_entry();
        check_entry(8'd67, 16'h2000, 16'h2400, 32'h0000_1000);
        irq_req = '0;

        // R7 trace and master cleared
        do_reset();
        set_status(16'h9300);
        irq_req = 8'h08;
        run_entry();
        check_entry(8'd67, 16'h9300, 16'h2400, 32'd0);
        irq_req = '0;

        // R11 reserved status bits
        do_reset();
        set_status(16'hFFFF);
        check("R11 reserved bits zero", 32'(status), 32'h0000_B71F);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule